// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the instructions of a speculative out-of-order core in program order while they are in flight. Every instruction that is issued takes one slot of a circular buffer, and the slot number goes back to the issue logic as the rename tag for the pending result. Execution units finish in any order and put their results on a shared result bus. Each result carries the tag of its slot, and the buffer stores the result in that slot and marks the slot finished.

Slots leave only from the oldest end, one per cycle, and only after their result has arrived. A retiring register operation writes the register file. A retiring store writes memory at the address it was given at issue. A retiring branch whose result says it was mispredicted throws away every younger slot and sends fetch to the correct successor address, which arrives as that branch's result value. The register file is written only by the newest in-flight producer of each register: an older producer that has been superseded retires without writing.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, and `rf_we`, `st_we` and `flush` are 0.
- R2: While fewer than DEPTH slots are held, `iss_ready` is 1. An issue accepted with `iss_valid` gets the slot shown on `iss_tag`. Successive accepted issues get successive slot numbers, and the numbers wrap from DEPTH-1 to 0.
- R3: When DEPTH slots are held, `iss_ready` is 0 and an `iss_valid` pulse takes no slot and changes nothing. `iss_ready` stays 0 during the cycle in which a slot of the full buffer retires.
- R4: A result with `res_valid` high and `res_tag` naming a held slot stores `res_value` and `res_mispredict` in that slot and marks it finished. A result that names a free slot is dropped.
- R5: Only the oldest slot retires, only once its result is present, and at most one slot retires per cycle. Its retire outputs are visible during the cycle after its result was captured, or during the cycle after the older slot retired.
- R6: A retiring register operation (kind 2'b00) drives `rf_we`=1 with `rf_idx` set to its destination register and `rf_data` set to its result.
- R7: A retiring store (kind 2'b01) drives `st_we`=1 with `st_addr` set to the address given at issue and `st_data` set to its result.
- R8: A retiring branch (kind 2'b10) whose misprediction bit is 0 frees its slot and drives none of `rf_we`, `st_we` or `flush`.
- R9: A retiring branch whose misprediction bit is 1 drives `flush`=1 and `redirect_pc` set to its result value for one cycle, with `iss_ready`=0 in that cycle. All younger slots are discarded: none of them retires, and the next issued slot number is the one just after the branch.
- R10: A result that arrives in the flush cycle is dropped. The slot it names does not count as finished when it is issued again later.
- R11: A retiring register operation drives `rf_we`=0 when a younger in-flight register operation targets the same register. Its slot is still freed.
- R12: Slots freed by retirement or by flush can be allocated again.
- R13: The reserved kind 2'b11 retires once its result is present and drives none of `rf_we`, `st_we` or `flush`, whatever its misprediction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind: 00 register op, 01 store, 10 branch, 11 reserved |
| iss_dst | input | REG_W | Destination register of a register op |
| iss_addr | input | ADDR_W | Memory address of a store |
| iss_ready | output | 1 | A free slot exists and no flush is in progress |
| iss_tag | output | TAG_W | Slot number the next accepted issue receives |
| res_valid | input | 1 | Result bus valid |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_value | input | DATA_W | Result value, or the correct successor address for a branch |
| res_mispredict | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Register file write at retirement |
| rf_idx | output | REG_W | Register written |
| rf_data | output | DATA_W | Data written to the register |
| st_we | output | 1 | Memory store at retirement |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Misprediction flush; all younger slots are discarded |
| redirect_pc | output | DATA_W | Fetch restart address during `flush` |

## Verification
The hardest case to reach is a result that arrives in the very cycle the flush happens and names a slot that is being discarded. The stimulus sets this up by issuing a register op, a branch, a register op and a store. It completes the youngest entries first, then completes the branch as mispredicted, and puts the result for the discarded store slot on the bus exactly in the flush cycle. It then issues into the same slot numbers again and shows that the reused store slot waits for a fresh result. Filling all slots so the tag wraps, and two writers to one register, are reached by issue sequences whose results are delayed on purpose.

// File: rtl/irb_pkg.sv
package irb_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10,
        KIND_RSVD   = 2'b11
    } kind_e;

    function automatic logic is_reg_kind(input kind_e k);
        return k == KIND_REG;
    endfunction

endpackage

// File: rtl/irb_ptr_ctrl.sv
module irb_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t st_d, st_q;

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            // the mispredicted branch at the head retires with the flush
            st_d.head  = step(st_q.head);
            st_d.tail  = step(st_q.head);
            st_d.count = '0;
        end else begin
            if (alloc)  st_d.tail = step(st_q.tail);
            if (retire) st_d.head = step(st_q.head);
            case ({alloc, retire})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign count = st_q.count;

endmodule

// File: rtl/irb_slot_array.sv
module irb_slot_array #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int REG_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic [TAG_W-1:0]    alloc_tag,
    input  logic [1:0]          alloc_kind,
    input  logic [REG_W-1:0]    alloc_dst,
    input  logic [ADDR_W-1:0]   alloc_addr,
    input  logic                res_valid,
    input  logic [TAG_W-1:0]    res_tag,
    input  logic [DATA_W-1:0]   res_value,
    input  logic                res_mis,
    input  logic                retire_en,
    input  logic                flush,
    input  logic [TAG_W-1:0]    head_tag,
    output logic                head_busy,
    output logic                head_done,
    output logic                head_mis,
    output irb_pkg::kind_e      head_kind,
    output logic [REG_W-1:0]    head_dst,
    output logic [ADDR_W-1:0]   head_addr,
    output logic [DATA_W-1:0]   head_value
);

    typedef struct packed {
        logic [DEPTH-1:0]             busy;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0]             mis;
        logic [DEPTH-1:0][1:0]        kind;
        logic [DEPTH-1:0][REG_W-1:0]  dst;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] value;
    } slots_t;

    slots_t st_d, st_q;
    logic [DEPTH-1:0] res_hit;

    // one comparator per slot; results to free slots or during flush are dropped
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign res_hit[g] = res_valid && !flush && st_q.busy[g]
                            && (res_tag == TAG_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (res_hit[i]) begin
                st_d.done[i]  = 1'b1;
                st_d.mis[i]   = res_mis;
                st_d.value[i] = res_value;
            end
        end
        if (retire_en) begin
            st_d.busy[head_tag] = 1'b0;
            st_d.done[head_tag] = 1'b0;
            st_d.mis[head_tag]  = 1'b0;
        end
        if (alloc_en) begin
            st_d.busy[alloc_tag]  = 1'b1;
            st_d.done[alloc_tag]  = 1'b0;
            st_d.mis[alloc_tag]   = 1'b0;
            st_d.kind[alloc_tag]  = alloc_kind;
            st_d.dst[alloc_tag]   = alloc_dst;
            st_d.addr[alloc_tag]  = alloc_addr;
            st_d.value[alloc_tag] = '0;
        end
        if (flush) begin
            st_d.busy = '0;
            st_d.done = '0;
            st_d.mis  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_busy  = st_q.busy[head_tag];
    assign head_done  = st_q.done[head_tag];
    assign head_mis   = st_q.mis[head_tag];
    assign head_kind  = irb_pkg::kind_e'(st_q.kind[head_tag]);
    assign head_dst   = st_q.dst[head_tag];
    assign head_addr  = st_q.addr[head_tag];
    assign head_value = st_q.value[head_tag];

endmodule

// File: rtl/irb_tag_map.sv
module irb_tag_map #(
    parameter int REG_W = 4,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [REG_W-1:0] alloc_reg,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             commit_en,
    input  logic [REG_W-1:0] commit_reg,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             flush,
    output logic             commit_match
);

    localparam int NREG = 1 << REG_W;

    typedef struct packed {
        logic [NREG-1:0]            pend;
        logic [NREG-1:0][TAG_W-1:0] tag;
    } map_t;

    map_t st_d, st_q;

    assign commit_match = st_q.pend[commit_reg] && (st_q.tag[commit_reg] == commit_tag);

    always_comb begin
        st_d = st_q;
        if (commit_en && commit_match) st_d.pend[commit_reg] = 1'b0;
        // a new producer of the same register takes precedence over the clear
        if (alloc_en) begin
            st_d.pend[alloc_reg] = 1'b1;
            st_d.tag[alloc_reg]  = alloc_tag;
        end
        if (flush) st_d.pend = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [ADDR_W-1:0] iss_addr,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_mispredict,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_data,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              flush,
    output logic [DATA_W-1:0] redirect_pc
);

    import irb_pkg::*;

    logic [TAG_W-1:0]  head_ptr, tail_ptr;
    logic [CNT_W-1:0]  occ_cnt;
    logic              alloc, retire;
    logic              head_busy, head_done, head_mis;
    kind_e             head_kind;
    logic [REG_W-1:0]  head_dst;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_value;
    logic              tag_match;
    logic              alloc_reg_op;

    assign retire       = head_busy && head_done;
    assign flush        = retire && (head_kind == KIND_BRANCH) && head_mis;
    assign iss_ready    = (occ_cnt != CNT_W'(DEPTH)) && !flush;
    assign alloc        = iss_valid && iss_ready;
    assign iss_tag      = tail_ptr;
    assign alloc_reg_op = alloc && is_reg_kind(kind_e'(iss_kind));

    irb_ptr_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (alloc),
        .retire (retire),
        .flush  (flush),
        .head   (head_ptr),
        .tail   (tail_ptr),
        .count  (occ_cnt)
    );

    irb_slot_array #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc),
        .alloc_tag  (tail_ptr),
        .alloc_kind (iss_kind),
        .alloc_dst  (iss_dst),
        .alloc_addr (iss_addr),
        .res_valid  (res_valid),
        .res_tag    (res_tag),
        .res_value  (res_value),
        .res_mis    (res_mispredict),
        .retire_en  (retire),
        .flush      (flush),
        .head_tag   (head_ptr),
        .head_busy  (head_busy),
        .head_done  (head_done),
        .head_mis   (head_mis),
        .head_kind  (head_kind),
        .head_dst   (head_dst),
        .head_addr  (head_addr),
        .head_value (head_value)
    );

    irb_tag_map #(.REG_W(REG_W), .TAG_W(TAG_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (alloc_reg_op),
        .alloc_reg    (iss_dst),
        .alloc_tag    (tail_ptr),
        .commit_en    (retire && head_kind == KIND_REG),
        .commit_reg   (head_dst),
        .commit_tag   (head_ptr),
        .flush        (flush),
        .commit_match (tag_match)
    );

    assign rf_we       = retire && (head_kind == KIND_REG) && tag_match;
    assign rf_idx      = head_dst;
    assign rf_data     = head_value;
    assign st_we       = retire && (head_kind == KIND_STORE);
    assign st_addr     = head_addr;
    assign st_data     = head_value;
    assign redirect_pc = head_value;

endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_ready,
    input logic [CNT_W-1:0] count,
    input logic [TAG_W-1:0] head,
    input logic [TAG_W-1:0] tail,
    input logic             rf_we,
    input logic             st_we,
    input logic             flush
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == DEPTH) |-> !iss_ready);

    p_single_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_we, flush}));

    p_retire_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_we || flush) |-> (count != '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (int'(count) == int'($past(count))
                 || int'(count) == int'($past(count)) + 1
                 || int'(count) + 1 == int'($past(count))));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    p_flush_no_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_ready);

    p_empty_ptrs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head == tail));

endmodule

bind inorder_retire_buf irb_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_ready (iss_ready),
    .count     (occ_cnt),
    .head      (head_ptr),
    .tail      (tail_ptr),
    .rf_we     (rf_we),
    .st_we     (st_we),
    .flush     (flush)
);

// File: tb/inorder_retire_buf_tb.sv
module inorder_retire_buf_tb;

    localparam int DEPTH  = 8;
    localparam int REG_W  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [1:0]        iss_kind = '0;
    logic [REG_W-1:0]  iss_dst = '0;
    logic [ADDR_W-1:0] iss_addr = '0;
    logic              iss_ready;
    logic [TAG_W-1:0]  iss_tag;
    logic              res_valid = 1'b0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [DATA_W-1:0] res_value = '0;
    logic              res_mispredict = 1'b0;
    logic              rf_we;
    logic [REG_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_data;
    logic              st_we;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic              flush;
    logic [DATA_W-1:0] redirect_pc;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    inorder_retire_buf #(.DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_addr(iss_addr),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .res_mispredict(res_mispredict),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_issue(input logic [1:0] k, input logic [REG_W-1:0] r,
                            input logic [ADDR_W-1:0] a, output logic [TAG_W-1:0] t);
        iss_valid = 1'b1; iss_kind = k; iss_dst = r; iss_addr = a;
        t = iss_tag;
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic do_bc(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v, input logic m);
        res_valid = 1'b1; res_tag = t; res_value = v; res_mispredict = m;
        @(negedge clk);
        res_valid = 1'b0; res_mispredict = 1'b0;
    endtask

    task automatic t_reset();
        chk(iss_ready == 1'b1, "R1 ready", 32'(iss_ready), 1);
        chk(iss_tag == 0, "R1 tag", 32'(iss_tag), 0);
        chk({rf_we, st_we, flush} == 3'b000, "R1 outputs", 32'({rf_we, st_we, flush}), 0);
    endtask

    task automatic t_inorder();
        logic [TAG_W-1:0] t;
        do_issue(2'b00, 4'd3, '0, t);      chk(t == 0, "R2 tag0", 32'(t), 0);
        do_issue(2'b00, 4'd5, '0, t);      chk(t == 1, "R2 tag1", 32'(t), 1);
        do_issue(2'b01, 4'd0, 16'h0100, t); chk(t == 2, "R2 tag2", 32'(t), 2);
        do_bc(3'd1, 32'h22, 1'b0);
        chk(rf_we == 1'b0, "R5 younger waits", 32'(rf_we), 0);
        do_bc(3'd2, 32'h33, 1'b0);
        chk(st_we == 1'b0 && rf_we == 1'b0, "R5 store waits", 32'({rf_we, st_we}), 0);
        do_bc(3'd0, 32'h11, 1'b0);
        chk(rf_we && rf_idx == 3 && rf_data == 32'h11, "R6 reg write", rf_data, 32'h11);
        tick();
        chk(rf_we && rf_idx == 5 && rf_data == 32'h22, "R5 order second", rf_data, 32'h22);
        tick();
        chk(st_we && !rf_we && st_addr == 16'h0100 && st_data == 32'h33, "R7 store",
            32'(st_addr), 32'h100);
        tick();
        chk(!st_we && iss_tag == 3, "R5 drained", 32'(iss_tag), 3);
    endtask

    task automatic t_full();
        logic [TAG_W-1:0] t;
        for (int i = 0; i < DEPTH; i++) begin
            do_issue(2'b00, REG_W'(i + 1), '0, t);
            chk(t == TAG_W'((3 + i) % DEPTH), "R12 wrap tag", 32'(t), 32'((3 + i) % DEPTH));
        end
        chk(iss_ready == 1'b0, "R3 full", 32'(iss_ready), 0);
        iss_valid = 1'b1; iss_kind = 2'b01; iss_addr = 16'h00AA;
        tick();
        iss_valid = 1'b0;
        chk(iss_tag == 3 && !iss_ready, "R3 ignored issue", 32'(iss_tag), 3);
        do_bc(3'd3, 32'd100, 1'b0);
        chk(rf_we && rf_idx == 1 && rf_data == 100, "R6 full head", rf_data, 100);
        chk(iss_ready == 1'b0, "R3 ready during retire", 32'(iss_ready), 0);
        tick();
        chk(iss_ready == 1'b1 && iss_tag == 3, "R12 slot freed", 32'(iss_tag), 3);
        for (int i = 1; i < DEPTH; i++) begin
            do_bc(TAG_W'((3 + i) % DEPTH), 32'(100 + i), 1'b0);
            chk(rf_we && rf_idx == REG_W'(i + 1) && rf_data == 32'(100 + i),
                "R5 drain order", rf_data, 32'(100 + i));
        end
        tick();
        chk(!st_we && !rf_we && iss_tag == 3, "R3 no phantom store", 32'({rf_we, st_we}), 0);
    endtask

    task automatic t_free_result();
        logic [TAG_W-1:0] t;
        do_bc(3'd3, 32'h99, 1'b0);
        do_issue(2'b00, 4'd9, '0, t);
        chk(t == 3, "R12 reuse", 32'(t), 3);
        tick();
        tick();
        chk(rf_we == 1'b0, "R4 free-slot result dropped", 32'(rf_we), 0);
        do_bc(3'd3, 32'h7, 1'b0);
        chk(rf_we && rf_idx == 9 && rf_data == 7, "R4 result captured", rf_data, 7);
        tick();
    endtask

    task automatic t_branch_ok();
        logic [TAG_W-1:0] t;
        do_issue(2'b10, '0, '0, t);
        chk(t == 4, "R2 branch tag", 32'(t), 4);
        do_bc(3'd4, 32'h40, 1'b0);
        chk({rf_we, st_we, flush} == 3'b000, "R8 quiet retire", 32'({rf_we, st_we, flush}), 0);
        tick();
        chk(iss_tag == 5 && iss_ready, "R8 freed", 32'(iss_tag), 5);
    endtask

    task automatic t_mispredict();
        logic [TAG_W-1:0] t;
        do_issue(2'b00, 4'd2, '0, t);
        do_issue(2'b10, '0, '0, t);
        do_issue(2'b00, 4'd4, '0, t);
        do_issue(2'b01, '0, 16'h0200, t);
        chk(t == 0, "R2 wrap", 32'(t), 0);
        do_bc(3'd7, 32'h5, 1'b0);
        chk(rf_we == 1'b0, "R5 wait", 32'(rf_we), 0);
        do_bc(3'd5, 32'h1, 1'b0);
        chk(rf_we && rf_idx == 2, "R6 before branch", 32'(rf_idx), 2);
        do_bc(3'd6, 32'h240, 1'b1);
        chk(flush && redirect_pc == 32'h240, "R9 flush redirect", redirect_pc, 32'h240);
        chk(!iss_ready && !rf_we && !st_we, "R9 flush cycle", 32'({iss_ready, rf_we, st_we}), 0);
        do_bc(3'd0, 32'h77, 1'b0);
        chk(!flush && iss_ready && iss_tag == 7, "R9 tail after flush", 32'(iss_tag), 7);
        chk(rf_we == 1'b0, "R9 younger discarded", 32'(rf_we), 0);
        tick();
        chk(!rf_we && !st_we, "R9 nothing retires", 32'({rf_we, st_we}), 0);
        do_issue(2'b00, 4'd4, '0, t);
        chk(t == 7, "R12 reissue", 32'(t), 7);
        do_issue(2'b01, '0, 16'h0300, t);
        do_bc(3'd7, 32'h5A, 1'b0);
        chk(rf_we && rf_idx == 4 && rf_data == 32'h5A, "R6 after flush", rf_data, 32'h5A);
        tick();
        chk(st_we == 1'b0, "R10 flush-cycle result dropped", 32'(st_we), 0);
        tick();
        chk(st_we == 1'b0, "R10 still waiting", 32'(st_we), 0);
        do_bc(3'd0, 32'h55, 1'b0);
        chk(st_we && st_addr == 16'h0300 && st_data == 32'h55, "R7 store after flush",
            st_data, 32'h55);
        tick();
    endtask

    task automatic t_same_dest();
        logic [TAG_W-1:0] t;
        do_issue(2'b00, 4'd6, '0, t);
        chk(t == 1, "R2 tag", 32'(t), 1);
        do_issue(2'b00, 4'd6, '0, t);
        do_bc(3'd1, 32'd10, 1'b0);
        chk(rf_we == 1'b0, "R11 superseded write", 32'(rf_we), 0);
        do_bc(3'd2, 32'd20, 1'b0);
        chk(rf_we && rf_idx == 6 && rf_data == 20, "R11 newest writes", rf_data, 20);
        tick();
    endtask

    task automatic t_reserved();
        logic [TAG_W-1:0] t;
        do_issue(2'b11, 4'd7, '0, t);
        chk(t == 3, "R13 tag", 32'(t), 3);
        do_bc(3'd3, 32'hDEAD, 1'b1);
        chk({rf_we, st_we, flush} == 3'b000, "R13 no effect", 32'({rf_we, st_we, flush}), 0);
        tick();
        chk(iss_tag == 4 && iss_ready, "R13 freed", 32'(iss_tag), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inorder();
        t_full();
        t_free_result();
        t_branch_ok();
        t_mispredict();
        t_same_dest();
        t_reserved();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule